// File: doc/BRIEF.md
# GNSS serial I/Q sample capture

This block takes the one-bit serial baseband output of a GNSS radio front end, together with that front end's bit clock and a frame marker. The frame marker is high during the first bit of each four-bit frame. The block moves the three serial lines into the system clock domain and finds the bit boundaries from the rising edges of the serial clock. It then rebuilds each complex sample, which is a sign bit and a magnitude bit for each of I and Q.

Samples are packed eight to a 32-bit word and written into an on-chip capture buffer. A processor controls capture through a small register bus: it starts and stops capture, clears the sticky flags, reads the status and the fill level, and reads back the buffer. The system clock must run at least four times faster than the serial clock. The buffer depth must be a power of two.

Top module: `gnss_iq_capture`

## Requirements
- R1: Serial bits are taken on rising edges of `sclk_in`. Each frame carries four bits in this order: I sign, I magnitude, Q sign, Q magnitude. `sfrm_in` high on a bit marks that bit as the I sign bit.
- R2: A decoded sample is a 4-bit nibble. Bit 3 is the Q sign, bit 2 the Q magnitude, bit 1 the I sign and bit 0 the I magnitude.
- R3: Eight nibbles make one word. The first sample received lands in bits 31:28 and the last in bits 3:0. A word is written to the buffer only after all eight of its nibbles have arrived.
- R4: While capture is stopped, serial input is ignored. After a start, nothing is decoded until the first frame marker is seen. Until then the locked status bit stays 0.
- R5: If a frame marker arrives while locked and the bit counter is not at a frame start, the counter realigns to that bit and the partial frame is dropped. The sticky resync flag is also set.
- R6: If a word completes while the buffer already holds DEPTH words, the word is dropped, the sticky overflow flag is set and capture stops. The fill level never exceeds DEPTH.
- R7: A start request is refused while the overflow flag is set. An accepted start resets the fill level to 0 and discards any partly packed word.
- R8: Register map:
  - Writing address 0 controls capture. Bit 1 = 1 clears both sticky flags, and this clear takes effect before bit 0 is looked at. Bit 0 = 1 requests a start; if capture is already running, this has no effect. Bit 0 = 0 stops capture.
  - Reading address 0 returns the status: bit 0 running, bit 1 overflow, bit 2 resync, bit 3 locked.
  - Reading address 1 returns the fill level in words.
  - When the top address bit is set, the low address bits select a buffer word to read.
  - Read data appears one clock after the address.
- R9: After reset, the status and the fill level are 0.
- R10: Stopping capture keeps the fill level and the stored words unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock from the front end |
| sdat_in | input | 1 | Serial sample data |
| sfrm_in | input | 1 | Frame marker, high on the I sign bit |
| csr_addr | input | log2(DEPTH)+1 | Register/buffer address |
| csr_we | input | 1 | Write strobe (address 0 only) |
| csr_wdata | input | 2 | Control write data: bit 1 clear flags, bit 0 run |
| csr_rdata | output | 32 | Read data, one cycle after the address |

## Verification
The hardest states to reach from the ports are a frame marker that arrives in the middle of a frame while the decoder is locked, and a word that completes against a full buffer.

For the first, the bench sends a partial frame followed by an early marker. It then checks that the resync flag is set and that the packed words follow the new alignment. For the second, the bench shrinks the buffer to eight words. It streams one word past capacity and then more frames after that. Finally it tries a plain restart, which must be refused, and then a clear-and-restart, which must be accepted.

// File: rtl/gnss_iq_pkg.sv
package gnss_iq_pkg;
  typedef struct packed {
    logic q_sgn;
    logic q_mag;
    logic i_sgn;
    logic i_mag;
  } iq_nib_t;

  localparam int REG_CTRL = 0;
  localparam int REG_FILL = 1;
endpackage

// File: rtl/gnss_ser_sync.sv
module gnss_ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdat_in,
  input  logic sfrm_in,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_frm
);
  // Serial clock gets one extra stage for rising-edge detection.
  logic [STAGES:0]   ck_sr;
  logic [STAGES-1:0] d_sr;
  logic [STAGES-1:0] f_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sr   <= '0;
      d_sr    <= '0;
      f_sr    <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
      bit_frm <= 1'b0;
    end else begin
      ck_sr   <= {ck_sr[STAGES-1:0], sclk_in};
      d_sr    <= {d_sr[STAGES-2:0], sdat_in};
      f_sr    <= {f_sr[STAGES-2:0], sfrm_in};
      bit_stb <= ck_sr[STAGES-1] & ~ck_sr[STAGES];
      bit_val <= d_sr[STAGES-1];
      bit_frm <= f_sr[STAGES-1];
    end
  end

  // R1: with a system clock at least 4x the serial clock, strobes never touch
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/gnss_frame_dec.sv
module gnss_frame_dec
  import gnss_iq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    bit_stb,
  input  logic    bit_val,
  input  logic    bit_frm,
  output iq_nib_t nib,
  output logic    nib_vld,
  output logic    resync,
  output logic    locked
);
  logic [1:0] pos;
  logic [2:0] part;   // I sign, I magnitude, Q sign held until Q magnitude

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos     <= 2'd0;
      locked  <= 1'b0;
      nib_vld <= 1'b0;
      resync  <= 1'b0;
    end else begin
      nib_vld <= 1'b0;
      resync  <= 1'b0;
      if (bit_stb) begin
        if (bit_frm) begin
          resync  <= locked && (pos != 2'd0);
          locked  <= 1'b1;
          part[0] <= bit_val;
          pos     <= 2'd1;
        end else if (locked) begin
          case (pos)
            2'd0: part[0] <= bit_val;
            2'd1: part[1] <= bit_val;
            2'd2: part[2] <= bit_val;
            default: begin
              nib     <= '{q_sgn: part[2], q_mag: bit_val,
                           i_sgn: part[0], i_mag: part[1]};
              nib_vld <= 1'b1;
            end
          endcase
          pos <= pos + 2'd1;
        end
      end
    end
  end

  // R5: a resync pulse only comes from an already locked decoder
  a_r5_resync_locked: assert property (@(posedge clk) disable iff (rst)
    resync |-> locked);
  // R1: one sample per four serial bits, never on adjacent cycles
  a_r1_nib_spacing: assert property (@(posedge clk) disable iff (rst)
    nib_vld |=> !nib_vld);
endmodule

// File: rtl/gnss_nib_pack.sv
module gnss_nib_pack
  import gnss_iq_pkg::*;
#(
  parameter int NIBS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  iq_nib_t           nib,
  input  logic              nib_vld,
  output logic [4*NIBS-1:0] word,
  output logic              word_vld
);
  localparam int WW = 4 * NIBS;
  localparam int CW = $clog2(NIBS);

  logic [CW-1:0] cnt;
  logic [WW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (nib_vld) begin
        acc <= {acc[WW-5:0], nib};
        if (cnt == CW'(NIBS - 1)) begin
          word     <= {acc[WW-5:0], nib};
          word_vld <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a word is only ever completed by an arriving sample
  a_r3_word_on_sample: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(nib_vld));
endmodule

// File: rtl/gnss_iq_capture.sv
module gnss_iq_capture
  import gnss_iq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2,
  localparam int DW    = $clog2(DEPTH),
  localparam int AW    = DW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              sfrm_in,
  input  logic [AW-1:0]     csr_addr,
  input  logic              csr_we,
  input  logic [1:0]        csr_wdata,
  output logic [DATA_W-1:0] csr_rdata
);
  localparam int FW   = DW + 1;
  localparam int NIBS = DATA_W / 4;

  logic bit_stb, bit_val, bit_frm;
  iq_nib_t nib;
  logic nib_vld, resync_p, locked;
  logic [DATA_W-1:0] word;
  logic word_vld;

  logic running, ovf, rsy;
  logic [FW-1:0] fill;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q, reg_q;
  logic sel_buf;

  gnss_ser_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .sfrm_in(sfrm_in), .bit_stb(bit_stb), .bit_val(bit_val), .bit_frm(bit_frm));

  gnss_frame_dec u_dec (
    .clk(clk), .rst(rst), .en(running), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_frm(bit_frm), .nib(nib), .nib_vld(nib_vld), .resync(resync_p),
    .locked(locked));

  gnss_nib_pack #(.NIBS(NIBS)) u_pack (
    .clk(clk), .rst(rst), .en(running), .nib(nib), .nib_vld(nib_vld),
    .word(word), .word_vld(word_vld));

  logic ctrl_wr, clr, start, stop, full, wr_ok;
  always_comb begin
    ctrl_wr = csr_we && (csr_addr == AW'(REG_CTRL));
    clr     = ctrl_wr && csr_wdata[1];
    start   = ctrl_wr && csr_wdata[0] && !running && (clr || !ovf);
    stop    = ctrl_wr && !csr_wdata[0];
    full    = (fill == FW'(DEPTH));
    wr_ok   = running && word_vld && !full && !stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ovf     <= 1'b0;
      rsy     <= 1'b0;
      fill    <= '0;
    end else begin
      if (clr) begin
        ovf <= 1'b0;
        rsy <= 1'b0;
      end
      if (resync_p) rsy <= 1'b1;
      if (start) begin
        running <= 1'b1;
        fill    <= '0;
      end else if (stop) begin
        running <= 1'b0;
      end else if (running && word_vld) begin
        if (full) begin
          ovf     <= 1'b1;
          running <= 1'b0;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  // Buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_ok) mem[fill[DW-1:0]] <= word;
    mem_q <= mem[csr_addr[DW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_buf <= 1'b0;
      reg_q   <= '0;
    end else begin
      sel_buf <= csr_addr[AW-1];
      if (csr_addr == AW'(REG_FILL)) reg_q <= DATA_W'(fill);
      else reg_q <= {{(DATA_W-4){1'b0}}, locked, rsy, ovf, running};
    end
  end

  assign csr_rdata = sel_buf ? mem_q : reg_q;

  // R6: the fill level is bounded by the buffer depth
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));
  // R6: a word arriving against a full buffer stops capture with overflow
  a_r6_full_stops: assert property (@(posedge clk) disable iff (rst)
    (running && word_vld && full && !ctrl_wr) |=> (ovf && !running));
  // R7: no restart while overflow is pending
  a_r7_start_blocked: assert property (@(posedge clk) disable iff (rst)
    (ovf && ctrl_wr && !csr_wdata[1]) |=> !running);
  // R5: resync flag holds until cleared
  a_r5_resync_sticky: assert property (@(posedge clk) disable iff (rst)
    (rsy && !clr) |=> rsy);
  // R10: while stopped the fill level does not move
  a_r10_fill_frozen: assert property (@(posedge clk) disable iff (rst)
    (!running && !ctrl_wr) |=> $stable(fill));
endmodule

// File: tb/gnss_iq_capture_tb.sv
module gnss_iq_capture_tb;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk_in = 1'b0, sdat_in = 1'b0, sfrm_in = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic csr_we = 1'b0;
  logic [1:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  int ntot = 0, nbad = 0;

  // Behavioural reference model
  bit mrun, movf, mrsy, mlock;
  int mpos, ncnt;
  bit mb[3];
  logic [31:0] macc;
  logic [31:0] mq[$];

  always #5 clk = ~clk;

  gnss_iq_capture #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .sfrm_in(sfrm_in), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_nibble(input logic [3:0] n);
    macc = {macc[27:0], n};
    ncnt++;
    if (ncnt == 8) begin
      ncnt = 0;
      if (mq.size() < DEPTH) mq.push_back(macc);
      else begin movf = 1; mrun = 0; mlock = 0; end
    end
  endtask

  task automatic m_bit(input bit d, input bit f);
    if (!mrun) return;
    if (f) begin
      if (mlock && mpos != 0) mrsy = 1;
      mlock = 1; mb[0] = d; mpos = 1;
    end else if (mlock) begin
      if (mpos == 3) begin
        m_nibble({mb[2], d, mb[0], mb[1]});
        mpos = 0;
      end else begin
        mb[mpos] = d; mpos++;
      end
    end
  endtask

  task automatic send_bit(input bit d, input bit f);
    sdat_in = d; sfrm_in = f;
    #60 sclk_in = 1'b1;
    m_bit(d, f);
    #60 sclk_in = 1'b0;
  endtask

  // n: bit3 Q sign, bit2 Q mag, bit1 I sign, bit0 I mag
  task automatic send_frame(input logic [3:0] n, input bit f);
    send_bit(n[1], f);
    send_bit(n[0], 1'b0);
    send_bit(n[3], 1'b0);
    send_bit(n[2], 1'b0);
  endtask

  task automatic csr_write(input logic [1:0] d);
    @(negedge clk);
    csr_addr = '0; csr_we = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    if (d[1]) begin movf = 0; mrsy = 0; end
    if (d[0]) begin
      if (!mrun && !movf) begin
        mrun = 1; mlock = 0; ncnt = 0; mpos = 0; mq.delete();
      end
    end else begin
      mrun = 0; mlock = 0; ncnt = 0; mpos = 0;
    end
  endtask

  task automatic csr_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    repeat (12) @(negedge clk);
    csr_read(AW'(0), v);
    chk({req, " status"}, v, {28'd0, mlock, mrsy, movf, mrun});
    csr_read(AW'(1), v);
    chk({req, " fill"}, v, mq.size());
    foreach (mq[i]) begin
      csr_read(AW'(DEPTH + i), v);
      chk({req, " word"}, v, mq[i]);
    end
  endtask

  initial begin
    #1_000_000;
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check_all("R9");

    // R4: stopped capture ignores serial input
    for (int i = 0; i < 8; i++) send_frame(4'hF, 1'b1);
    check_all("R4 stopped");

    // R4: after start, no decode before the first marker
    csr_write(2'b01);
    for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
    check_all("R4 unlocked");

    // R1 R2 R3: aligned frames, marker on every frame
    for (int i = 0; i < 16; i++) send_frame(i[3:0], 1'b1);
    check_all("R3 aligned");
    csr_read(AW'(DEPTH), v);
    chk("R3 oldest in MSB", v, 32'h01234567);
    csr_read(AW'(DEPTH + 1), v);
    chk("R2 second word", v, 32'h89ABCDEF);

    // R2: single-field patterns, marker only on the first frame (R1 counting)
    send_frame(4'h8, 1'b1);
    for (int i = 0; i < 7; i++) send_frame(4'h8 >> (i % 4), 1'b0);
    check_all("R2 fields");
    csr_read(AW'(DEPTH + 2), v);
    chk("R2 field order", v, 32'h88421842);

    // R3: partial word not written
    for (int i = 0; i < 4; i++) send_frame(4'hA, 1'b1);
    check_all("R3 partial");

    // R5: marker in the middle of a frame
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send_frame(4'h5, 1'b1);
    check_all("R5 resync");
    csr_read(AW'(DEPTH + 3), v);
    chk("R5 realigned word", v, 32'hAAAA7555);

    // R8: clear flags while running keeps capture on
    csr_write(2'b11);
    check_all("R8 clear");

    // R10: stop keeps content
    csr_write(2'b00);
    for (int i = 0; i < 16; i++) send_frame(4'h3, 1'b1);
    check_all("R10 stopped");

    // R6: overflow on a full buffer
    csr_write(2'b01);
    for (int i = 0; i < 8 * DEPTH; i++) send_frame(4'(i), 1'b1);
    check_all("R6 full");
    for (int i = 0; i < 16; i++) send_frame(4'hC, 1'b1);
    check_all("R6 overflow");
    csr_read(AW'(0), v);
    chk("R6 overflow flag", v[1:0], 2'b10);

    // R7: restart refused while overflow set, accepted with clear
    csr_write(2'b01);
    check_all("R7 refused");
    csr_write(2'b11);
    for (int i = 0; i < 8; i++) send_frame(4'h6, 1'b1);
    check_all("R7 restart");
    csr_read(AW'(1), v);
    chk("R7 fill after restart", v, 32'd1);

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule